// File: doc/BRIEF.md
# Programmable Master Video Sync Generator

This block produces the horizontal and vertical/field timing of an interlaced 625-line raster while acting as the timing master. A pixel-clock enable advances a pixel counter and a line counter. From their state the block derives a horizontal sync pulse, a combined field/vertical-sync output and the current line and pixel position. The position output is the reference that the pixel data stream is aligned to.

One 8-bit timing register shapes the pulses. It is written and read through a small parallel register port and decoded at address 08h. The two lowest bits pick the horizontal pulse width. The next two bits pick how far the field/vertical events sit from the horizontal pulse start. Bits 5:4 hold the field-edge offset in mode 1 and the vertical pulse width in mode 2. The top two bits shift the horizontal pulse, and every event tied to it, against the pixel position, so the chroma order seen at the sync edge can be swapped. A new register value does not act at once. It is taken at the next line start, so no pulse is cut short.

Top module: `vsg_master`

## Requirements
- R1: A write with `reg_we` high and `reg_addr` = 08h stores `reg_wdata`. `reg_rdata` shows the stored value one clock after `reg_addr` = 08h is presented, and shows 00h for any other address. A write to any other address leaves the stored value unchanged.
- R2: The horizontal pulse `hsync_o` (active high) covers W pixel positions starting at pixel S. W is set by bits [1:0]: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 128.
- R3: The pixel counter runs 0 to PPL-1 and the line counter runs 1 to LPF. Both advance only on a clock where `pix_en` is high. When the pixel counter wraps, the line counter advances, and line LPF is followed by line 1.
- R4: In mode 1 (`mode_i` = 0), `fv_o` is a field level. It goes high at line (LPF+1)/2+1, at pixel S+D, or at S+D+PPL/2 when bit 4 is 1. It goes low at line 1, at pixel S+D. Bit 5 has no effect in this mode.
- R5: The skew S equals bits [7:6], giving 0 to 3 pixels. S moves the horizontal pulse start and all field/vertical events by the same amount.
- R6: The offset D is set by bits [3:2]: 00 gives 0, 01 gives 4, 10 gives 8 and 11 gives 16 pixels. D is added to the position of every field/vertical event.
- R7: In mode 2 (`mode_i` = 1), `fv_o` is a vertical pulse V pixels long. One pulse starts at line 1, pixel S+D. The other starts at line (LPF+1)/2, pixel S+D+PPL/2. V is set by bits [5:4]: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 128.
- R8: The pulse logic uses a working copy of the register. That copy is loaded from the stored value only on a clock where `pix_en` is high and the pixel counter is at PPL-1.
- R9: Synchronous reset does the following:
  - clears the stored value, the working copy and `reg_rdata` to 00h;
  - sets the counters to line 1, pixel 0, with the field level low;
  - drives `hsync_o` and `fv_o` low, `line_o` to 1 and `pix_o` to 0.
- R10: All outputs are registered. `line_o`, `pix_o`, `hsync_o` and `fv_o` describe the counter position held before the latest clock edge, together with the pulse state at that position. `mode_i` is sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; advances the raster position |
| mode_i | input | 1 | Timing mode: 0 = field level, 1 = vertical pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| hsync_o | output | 1 | Horizontal sync pulse, active high |
| fv_o | output | 1 | Field level (mode 1) or vertical sync pulse (mode 2) |
| line_o | output | clog2(LPF+1) | Line number, 1 to LPF |
| pix_o | output | clog2(PPL) | Pixel position in the line |

## Verification
The assertions assume the following about the block and its inputs:
- The largest horizontal pulse end, S plus 128, lies well inside a line.
- The latest vertical event, S+D+PPL/2+128, also fits within one line.
- The two field lines are different from line 1.

The bench keeps to these limits by running the full 864-pixel line with a shortened 7-line frame. The mode input changes only while the register port is active, between runs. The pixel enable follows a gapped pattern, so that the stall behaviour is exercised as well.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef struct packed {
    logic [1:0] skew;   // [7:6] pixel skew of hsync and events
    logic [1:0] fsel;   // [5:4] field offset (mode 1) or vsync width (mode 2)
    logic [1:0] dsel;   // [3:2] event offset after hsync start
    logic [1:0] wsel;   // [1:0] hsync width
  } tcfg_t;

  function automatic logic [7:0] pulse_len(input logic [1:0] code);
    case (code)
      2'd0:    pulse_len = 8'd1;
      2'd1:    pulse_len = 8'd4;
      2'd2:    pulse_len = 8'd16;
      default: pulse_len = 8'd128;
    endcase
  endfunction

  function automatic logic [7:0] delay_len(input logic [1:0] code);
    case (code)
      2'd0:    delay_len = 8'd0;
      2'd1:    delay_len = 8'd4;
      2'd2:    delay_len = 8'd8;
      default: delay_len = 8'd16;
    endcase
  endfunction

endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
  import vsg_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'h08
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       line_end,
  output logic [7:0] rdata,
  output tcfg_t      cfg
);

  logic [7:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      cfg    <= '0;
      rdata  <= '0;
    end else begin
      if (line_end) cfg <= tcfg_t'(shadow);
      if (we && addr == REG_ADDR) shadow <= wdata;
      rdata <= (addr == REG_ADDR) ? shadow : 8'h00;
    end
  end

endmodule

// File: rtl/vsg_count.sv
module vsg_count #(
  parameter int PPL = 864,
  parameter int LPF = 625,
  localparam int PW = $clog2(PPL),
  localparam int LW = $clog2(LPF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  output logic [PW-1:0] pix,
  output logic [LW-1:0] line,
  output logic          line_end
);

  assign line_end = pix_en && (pix == PW'(PPL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pix  <= '0;
      line <= LW'(1);
    end else if (pix_en) begin
      if (pix == PW'(PPL - 1)) begin
        pix  <= '0;
        line <= (line == LW'(LPF)) ? LW'(1) : line + LW'(1);
      end else begin
        pix <= pix + PW'(1);
      end
    end
  end

endmodule

// File: rtl/vsg_pulse.sv
module vsg_pulse
  import vsg_pkg::*;
#(
  parameter int PPL = 864,
  parameter int LPF = 625,
  localparam int PW = $clog2(PPL),
  localparam int LW = $clog2(LPF + 1),
  localparam int SW = PW + 2,
  localparam int F2LINE = (LPF + 1) / 2 + 1,
  localparam int V2LINE = (LPF + 1) / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  tcfg_t         cfg,
  input  logic [PW-1:0] pix,
  input  logic [LW-1:0] line,
  output logic          hsync_o,
  output logic          fv_o,
  output logic [LW-1:0] line_o,
  output logic [PW-1:0] pix_o
);

  localparam logic [SW-1:0] HALF = SW'(PPL / 2);

  logic [SW-1:0] p, hs0, hs1, ev, rise, vlen, v2s;
  logic          hs_now, vs_now, fset, fclr, field_q, field_nx;

  always_comb begin
    p      = SW'(pix);
    hs0    = SW'(cfg.skew);
    hs1    = hs0 + SW'(pulse_len(cfg.wsel));
    ev     = hs0 + SW'(delay_len(cfg.dsel));
    rise   = cfg.fsel[0] ? ev + HALF : ev;
    vlen   = SW'(pulse_len(cfg.fsel));
    v2s    = ev + HALF;
    hs_now = (p >= hs0) && (p < hs1);
    vs_now = ((line == LW'(1)) && (p >= ev) && (p < ev + vlen)) ||
             ((line == LW'(V2LINE)) && (p >= v2s) && (p < v2s + vlen));
    fset   = (line == LW'(F2LINE)) && (p == rise);
    fclr   = (line == LW'(1)) && (p == ev);
    field_nx = fset ? 1'b1 : (fclr ? 1'b0 : field_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= 1'b0;
      hsync_o <= 1'b0;
      fv_o    <= 1'b0;
      line_o  <= LW'(1);
      pix_o   <= '0;
    end else begin
      field_q <= field_nx;
      hsync_o <= hs_now;
      fv_o    <= mode ? vs_now : field_nx;
      line_o  <= line;
      pix_o   <= pix;
    end
  end

endmodule

// File: rtl/vsg_master.sv
module vsg_master
  import vsg_pkg::*;
#(
  parameter int PPL = 864,
  parameter int LPF = 625,
  parameter logic [7:0] REG_ADDR = 8'h08,
  localparam int PW = $clog2(PPL),
  localparam int LW = $clog2(LPF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          mode_i,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          hsync_o,
  output logic          fv_o,
  output logic [LW-1:0] line_o,
  output logic [PW-1:0] pix_o
);

  tcfg_t         cfg;
  logic [PW-1:0] pix_q;
  logic [LW-1:0] line_q;
  logic          line_end;

  vsg_count #(.PPL(PPL), .LPF(LPF)) u_count (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .pix(pix_q), .line(line_q), .line_end(line_end)
  );

  vsg_regs #(.REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .line_end(line_end), .rdata(reg_rdata), .cfg(cfg)
  );

  vsg_pulse #(.PPL(PPL), .LPF(LPF)) u_pulse (
    .clk(clk), .rst(rst), .mode(mode_i), .cfg(cfg),
    .pix(pix_q), .line(line_q),
    .hsync_o(hsync_o), .fv_o(fv_o), .line_o(line_o), .pix_o(pix_o)
  );

endmodule

// File: rtl/vsg_master_chk.sv
module vsg_master_chk
  import vsg_pkg::*;
#(
  parameter int PPL = 864,
  parameter int LPF = 625,
  parameter logic [7:0] REG_ADDR = 8'h08,
  localparam int PW = $clog2(PPL),
  localparam int LW = $clog2(LPF + 1),
  localparam int F2LINE = (LPF + 1) / 2 + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          mode_i,
  input logic [7:0]    reg_addr,
  input logic [7:0]    reg_rdata,
  input logic          hsync_o,
  input logic          fv_o,
  input logic [LW-1:0] line_o,
  input logic [PW-1:0] pix_o,
  input tcfg_t         cfg,
  input logic [PW-1:0] pix_q
);

  p_pos_range_r3: assert property (@(posedge clk) disable iff (rst)
    (pix_o < PW'(PPL)) && (line_o >= LW'(1)) && (line_o <= LW'(LPF)));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(pix_en, 2) |-> $stable(pix_o));

  p_hs_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_o) |-> (pix_o == PW'(cfg.skew)));

  p_field_line_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_i) && !$past(mode_i, 2) && (fv_o != $past(fv_o)))
      |-> ((line_o == LW'(1)) || (line_o == LW'(F2LINE))));

  p_cfg_at_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg != $past(cfg)) |-> ($past(pix_en) && ($past(pix_q) == PW'(PPL - 1))));

  p_rd_other_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) != REG_ADDR) |-> (reg_rdata == 8'h00));

endmodule

bind vsg_master vsg_master_chk #(.PPL(PPL), .LPF(LPF), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .mode_i(mode_i), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .hsync_o(hsync_o), .fv_o(fv_o), .line_o(line_o),
  .pix_o(pix_o), .cfg(cfg), .pix_q(pix_q)
);

// File: tb/vsg_master_test.sv
module vsg_master_test;
  localparam int PPL = 864, LPF = 7, PW = 10, LW = 3;
  localparam int F2 = (LPF + 1) / 2 + 1, V2 = (LPF + 1) / 2, HALF = PPL / 2;

  logic clk = 1'b0, rst = 1'b1, pix_en = 1'b0, mode_i = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h08, reg_wdata = 8'h00, reg_rdata;
  logic hsync_o, fv_o;
  logic [LW-1:0] line_o;
  logic [PW-1:0] pix_o;

  int total = 0, bad = 0, cyc = 0;
  int ml, mp, mfield, mcfg, mshadow;
  int e_hs = 0, e_fv = 0, e_l = 1, e_p = 0, e_rd = 0;
  bit done = 0;

  vsg_master #(.PPL(PPL), .LPF(LPF)) uut (.*);

  always #5 clk = ~clk;

  function automatic int plen(int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 16 : 128;
  endfunction
  function automatic int dlen(int c);
    return (c == 0) ? 0 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, updated at each rising edge from pre-edge state
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      ml = 1; mp = 0; mfield = 0; mcfg = 0; mshadow = 0;
      e_hs = 0; e_fv = 0; e_l = 1; e_p = 0; e_rd = 0;
    end else begin
      int s, ev, rise, w, v, nf;
      bit vs;
      s = (mcfg >> 6) & 3;
      w = plen(mcfg & 3);
      v = plen((mcfg >> 4) & 3);
      ev = s + dlen((mcfg >> 2) & 3);
      rise = ev + ((((mcfg >> 4) & 1) != 0) ? HALF : 0);
      e_hs = (mp >= s && mp < s + w) ? 1 : 0;
      nf = mfield;
      if (ml == F2 && mp == rise) nf = 1;
      else if (ml == 1 && mp == ev) nf = 0;
      vs = (ml == 1 && mp >= ev && mp < ev + v) ||
           (ml == V2 && mp >= ev + HALF && mp < ev + HALF + v);
      e_fv = mode_i ? int'(vs) : nf;
      mfield = nf;
      e_l = ml; e_p = mp;
      e_rd = (reg_addr == 8'h08) ? mshadow : 0;
      if (pix_en && mp == PPL - 1) mcfg = mshadow;
      if (reg_we && reg_addr == 8'h08) mshadow = int'(reg_wdata);
      if (pix_en) begin
        if (mp == PPL - 1) begin
          mp = 0;
          ml = (ml == LPF) ? 1 : ml + 1;
        end else mp++;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      check("R2/R5/R8 hsync_o", int'(hsync_o), e_hs);
      check("R4/R6/R7 fv_o", int'(fv_o), e_fv);
      check("R3/R10 line_o", int'(line_o), e_l);
      check("R3/R10 pix_o", int'(pix_o), e_p);
      check("R1 reg_rdata", int'(reg_rdata), e_rd);
    end
  end

  // gapped pixel enable
  always @(negedge clk) pix_en <= !rst && ((cyc % 4) != 3);

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 8'h08;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk); reg_addr = a;
    @(negedge clk); check(tag, int'(reg_rdata), exp);
    reg_addr = 8'h08;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R9 reset hsync_o", int'(hsync_o), 0);
    check("R9 reset fv_o", int'(fv_o), 0);
    check("R9 reset line_o", int'(line_o), 1);
    check("R9 reset pix_o", int'(pix_o), 0);
    check("R9 reset reg_rdata", int'(reg_rdata), 0);
    rst = 1'b0;
    wr(8'h08, 8'h5A);
    rd(8'h08, 8'h5A, "R1 readback");
    wr(8'h09, 8'h33);
    rd(8'h08, 8'h5A, "R1 other-address write ignored");
    rd(8'h09, 0, "R1 other-address read");
    for (int i = 0; i < 16; i++) begin
      logic [3:0] k;
      k = 4'(i);
      wr(8'h08, {k[1:0], k[3:2], k[1:0] ^ k[3:2], ~k[1:0]});
      mode_i = k[0];
      repeat (8100) @(negedge clk);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule